// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a small multi-cycle processor built as a finite state machine with a datapath. It uses a single memory bus for both instructions and data. The bus has a registered address output, a write-data output, a read-data input and a write strobe. Every instruction word holds an opcode and one memory address. The accumulator is the implied second source and the destination of every operation. The controller fetches a word, decodes it, and then runs one execute state for the selected operation: add, subtract, load or store. In that last state it places the program counter back on the address bus, so the next fetch is already prepared.

Program and operands share one memory, so the operand access always falls in a later cycle than the instruction fetch. A defined instruction takes three cycles. An undefined opcode takes two cycles and changes nothing. A parameter chooses the arithmetic variant: either one adder with an inverted operand and carry-in handles both add and subtract, or two separate units do the job.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word is OP_W+ADDR_W bits wide. The opcode sits in the upper OP_W bits and the operand address in the lower ADDR_W bits. Opcode 0 is add, 1 is subtract, 2 is load and 3 is store. Every other code is undefined.
- R2: While `rst` is high at a rising clock edge, the program counter, instruction word and accumulator clear to zero. The zero flag reads 1, the address bus reads 0, the write strobe is low and the next cycle is a fetch.
- R3: In a fetch cycle the address bus shows the program counter and the write strobe is low. The word read back becomes the current instruction and the program counter steps by one.
- R4: A defined instruction uses three cycles: fetch, decode, execute. In the execute cycle the address bus shows the operand address. The cycle after execute is a fetch from the incremented program counter.
- R5: Add sets the accumulator to the accumulator plus the memory operand, modulo 2^WORD_W.
- R6: Subtract sets the accumulator to the accumulator minus the memory operand, modulo 2^WORD_W.
- R7: Load copies the memory operand into the accumulator.
- R8: Store raises the write strobe for exactly one cycle, the execute cycle. In that cycle the write data equals the accumulator and the address equals the operand address. The accumulator does not change.
- R9: After each add, subtract or load, the zero flag is 1 exactly when the new accumulator is zero. Store and undefined opcodes leave the flag alone.
- R10: An undefined opcode takes two cycles, fetch and decode. It writes nothing and leaves the accumulator unchanged. The next fetch reads the following address.
- R11: A word that a store writes into the program area is later fetched and executed as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Registered memory address |
| mem_wdata | output | OP_W+ADDR_W | Write data (accumulator) |
| mem_rdata | input | OP_W+ADDR_W | Read data, combinational from memory |
| mem_we | output | 1 | Write strobe |
| acc_out | output | OP_W+ADDR_W | Accumulator value |
| zero_out | output | 1 | Zero flag |

## Verification
The bench builds the block with ADDR_W=5, OP_W=3 and the shared-adder subtract variant. That gives 8-bit words and a 32-word memory, small enough to sweep operand pairs over a grid of 17 values per side, covering zero, 255 and pairs whose sum wraps to exactly zero.

The three-bit opcode leaves four undefined codes, and every one of them is run. A cycle-level instruction model in the bench predicts the address, strobe, accumulator and flag for every cycle. This model also covers a program that rewrites one of its own instruction slots.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_ADD   = 0;
   localparam int OPC_SUB   = 1;
   localparam int OPC_LOAD  = 2;
   localparam int OPC_STORE = 3;

   typedef enum logic [2:0] {
      ST_FETCH    = 3'd0,
      ST_DECODE   = 3'd1,
      ST_EX_ADD   = 3'd2,
      ST_EX_SUB   = 3'd3,
      ST_EX_LOAD  = 3'd4,
      ST_EX_STORE = 3'd5
   } cpu_state_e;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'd0,
      ALU_SUB  = 2'd1,
      ALU_PASS = 2'd2
   } alu_op_e;

   typedef enum logic [1:0] {
      ADR_HOLD = 2'd0,
      ADR_PC   = 2'd1,
      ADR_OPND = 2'd2
   } adr_sel_e;

   typedef struct packed {
      logic     ir_ld;
      logic     pc_inc;
      adr_sel_e adr_sel;
      logic     acc_ld;
      alu_op_e  alu_op;
      logic     mem_we;
   } ctrl_s;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] y
);

   if (DATA_W < 2) begin : g_bad_width
      $error("acc_cpu_alu: DATA_W must be at least 2");
   end

   if (SUB_VIA_ADDER) begin : g_shared
      logic [DATA_W-1:0] b_m;
      logic              cin;
      logic [DATA_W-1:0] sum;
      always_comb begin
         cin = (op == ALU_SUB);
         b_m = cin ? ~b : b;
      end
      assign sum = a + b_m + DATA_W'(cin);
      assign y   = (op == ALU_PASS) ? b : sum;
   end else begin : g_split
      always_comb begin
         case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
         endcase
      end
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int OP_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output ctrl_s           ctl
);

   if (OP_W < 2) begin : g_bad_op
      $error("acc_cpu_ctrl: OP_W must be at least 2");
   end

   cpu_state_e state_q, state_d;
   logic       is_add, is_sub, is_ld, is_st, is_def;

   assign is_add = (opcode == OP_W'(OPC_ADD));
   assign is_sub = (opcode == OP_W'(OPC_SUB));
   assign is_ld  = (opcode == OP_W'(OPC_LOAD));
   assign is_st  = (opcode == OP_W'(OPC_STORE));
   assign is_def = is_add | is_sub | is_ld | is_st;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      ctl     = '0;
      case (state_q)
         ST_FETCH: begin
            ctl.ir_ld  = 1'b1;
            ctl.pc_inc = 1'b1;
            state_d    = ST_DECODE;
         end
         ST_DECODE: begin
            ctl.adr_sel = ADR_OPND;
            if (is_add)     state_d = ST_EX_ADD;
            else if (is_sub) state_d = ST_EX_SUB;
            else if (is_ld)  state_d = ST_EX_LOAD;
            else if (is_st)  state_d = ST_EX_STORE;
            else begin
               ctl.adr_sel = ADR_PC;
               state_d     = ST_FETCH;
            end
         end
         ST_EX_ADD: begin
            ctl.acc_ld  = 1'b1;
            ctl.alu_op  = ALU_ADD;
            ctl.adr_sel = ADR_PC;
            state_d     = ST_FETCH;
         end
         ST_EX_SUB: begin
            ctl.acc_ld  = 1'b1;
            ctl.alu_op  = ALU_SUB;
            ctl.adr_sel = ADR_PC;
            state_d     = ST_FETCH;
         end
         ST_EX_LOAD: begin
            ctl.acc_ld  = 1'b1;
            ctl.alu_op  = ALU_PASS;
            ctl.adr_sel = ADR_PC;
            state_d     = ST_FETCH;
         end
         ST_EX_STORE: begin
            ctl.mem_we  = 1'b1;
            ctl.adr_sel = ADR_PC;
            state_d     = ST_FETCH;
         end
         default: state_d = ST_FETCH;
      endcase
   end

   // R3: a fetch is always followed by a decode
   a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_FETCH |=> state_q == ST_DECODE);

   // R4: every execute state hands back to fetch
   a_r4_exec_returns: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_FETCH && state_q != ST_DECODE) |=> state_q == ST_FETCH);

   // R8: the write strobe never lasts two cycles
   a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_we |=> !ctl.mem_we);

   // R10: an undefined code goes straight back to fetch
   a_r10_undef_skips: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DECODE && !is_def) |=> state_q == ST_FETCH);

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W        = 5,
   parameter int OP_W          = 3,
   parameter bit SUB_VIA_ADDER = 1'b1,
   localparam int WORD_W       = OP_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  ctrl_s             ctl,
   input  logic [WORD_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] wdata,
   output logic [OP_W-1:0]   opcode,
   output logic [WORD_W-1:0] acc,
   output logic              zero
);

   logic [ADDR_W-1:0] pc_q, addr_q;
   logic [WORD_W-1:0] ir_q, acc_q, alu_y;
   logic              zero_q;

   acc_cpu_alu #(
      .DATA_W        (WORD_W),
      .SUB_VIA_ADDER (SUB_VIA_ADDER)
   ) u_alu (
      .a  (acc_q),
      .b  (rdata),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         ir_q   <= '0;
         acc_q  <= '0;
         zero_q <= 1'b1;
         addr_q <= '0;
      end else begin
         if (ctl.ir_ld)  ir_q <= rdata;
         if (ctl.pc_inc) pc_q <= pc_q + ADDR_W'(1);
         if (ctl.acc_ld) begin
            acc_q  <= alu_y;
            zero_q <= ~|alu_y;
         end
         case (ctl.adr_sel)
            ADR_PC:   addr_q <= pc_q;
            ADR_OPND: addr_q <= ir_q[ADDR_W-1:0];
            default:  addr_q <= addr_q;
         endcase
      end
   end

   assign addr   = addr_q;
   assign wdata  = acc_q;
   assign opcode = ir_q[WORD_W-1 -: OP_W];
   assign acc    = acc_q;
   assign zero   = zero_q;

   // R3: program counter steps by one after each fetch
   a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
      ctl.pc_inc |=> pc_q == $past(pc_q) + ADDR_W'(1));

   // R5: add result taken from the bus operand
   a_r5_add_result: assert property (@(posedge clk) disable iff (rst)
      (ctl.acc_ld && ctl.alu_op == ALU_ADD) |=> acc_q == WORD_W'($past(acc_q) + $past(rdata)));

   // R6: subtract wraps modulo the word size
   a_r6_sub_result: assert property (@(posedge clk) disable iff (rst)
      (ctl.acc_ld && ctl.alu_op == ALU_SUB) |=> acc_q == WORD_W'($past(acc_q) - $past(rdata)));

   // R7: load copies the bus word
   a_r7_load_copy: assert property (@(posedge clk) disable iff (rst)
      (ctl.acc_ld && ctl.alu_op == ALU_PASS) |=> acc_q == $past(rdata));

   // R8: a store leaves the accumulator alone
   a_r8_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_we |=> $stable(acc_q));

   // R9: flag agrees with the accumulator
   a_r9_zero_tracks: assert property (@(posedge clk) disable iff (rst)
      zero_q == (acc_q == '0));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W        = 5,
   parameter int OP_W          = 3,
   parameter bit SUB_VIA_ADDER = 1'b1,
   localparam int WORD_W       = OP_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [WORD_W-1:0] acc_out,
   output logic              zero_out
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("acc_cpu: ADDR_W must be at least 2");
   end

   ctrl_s           ctl;
   logic [OP_W-1:0] opcode;

   acc_cpu_ctrl #(
      .OP_W (OP_W)
   ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .ctl    (ctl)
   );

   acc_cpu_dpath #(
      .ADDR_W        (ADDR_W),
      .OP_W          (OP_W),
      .SUB_VIA_ADDER (SUB_VIA_ADDER)
   ) u_dpath (
      .clk    (clk),
      .rst    (rst),
      .ctl    (ctl),
      .rdata  (mem_rdata),
      .addr   (mem_addr),
      .wdata  (mem_wdata),
      .opcode (opcode),
      .acc    (acc_out),
      .zero   (zero_out)
   );

   assign mem_we = ctl.mem_we;

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

   localparam int AW    = 5;
   localparam int OW    = 3;
   localparam int WW    = AW + OW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_wdata, mem_rdata, acc_out;
   logic          mem_we, zero_out;

   logic [WW-1:0] mem  [DEPTH];
   logic [WW-1:0] mm   [DEPTH];
   logic [WW-1:0] prog [DEPTH];
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [WW-1:0] ld_data = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   acc_cpu #(.ADDR_W(AW), .OP_W(OW), .SUB_VIA_ADDER(1'b1)) u0 (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .acc_out(acc_out), .zero_out(zero_out)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) begin
      if (ld_en)       mem[ld_addr]  <= ld_data;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
   end

   function automatic logic [WW-1:0] enc(input int op, input int a);
      return {op[OW-1:0], a[AW-1:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // load prog[] into memory and model while reset is held, then release
   task automatic start();
      rst = 1'b1;
      for (int a = 0; a < DEPTH; a++) begin
         ld_en = 1'b1; ld_addr = AW'(a); ld_data = prog[a];
         mm[a] = prog[a];
         @(negedge clk);
      end
      ld_en = 1'b0;
      rst   = 1'b0;
      // R2: reset state
      chk(mem_addr == '0, "R2 addr", int'(mem_addr), 0);
      chk(!mem_we, "R2 we", int'(mem_we), 0);
      chk(acc_out == '0, "R2 acc", int'(acc_out), 0);
      chk(zero_out, "R2 zero", int'(zero_out), 1);
   endtask

   // cycle-level instruction model
   task automatic run(input int n);
      int            pc;
      int            op, opa;
      logic [WW-1:0] w, macc;
      string         rq;
      pc = 0; macc = '0;
      for (int i = 0; i < n; i++) begin
         w = mm[pc]; op = int'(w[WW-1 -: OW]); opa = int'(w[AW-1:0]);
         // R3 / R4 / R10: fetch address
         chk(mem_addr == AW'(pc) && !mem_we, "R3 fetch addr", int'(mem_addr), pc);
         @(negedge clk);
         chk(!mem_we, "R4 decode strobe", int'(mem_we), 0);
         @(negedge clk);
         if (op < 4) begin
            chk(mem_addr == AW'(opa), "R4 operand addr", int'(mem_addr), opa);
            if (op == 3)
               chk(mem_we && mem_wdata == macc, "R8 store data", int'(mem_wdata), int'(macc));
            else
               chk(!mem_we, "R4 exec strobe", int'(mem_we), 0);
            @(negedge clk);
         end
         case (op)
            0: begin macc = macc + mm[opa]; rq = "R5 add acc"; end
            1: begin macc = macc - mm[opa]; rq = "R6 sub acc"; end
            2: begin macc = mm[opa];        rq = "R7 load acc"; end
            3: begin mm[opa] = macc;        rq = "R8 store acc"; end
            default: rq = "R10 undefined acc";
         endcase
         chk(acc_out == macc, rq, int'(acc_out), int'(macc));
         chk(zero_out == (macc == '0), "R9 zero flag", int'(zero_out), int'(macc == '0));
         pc = (pc + 1) % DEPTH;
      end
   endtask

   initial begin : main
      logic [WW-1:0] a, b;
      @(negedge clk);
      // operand grid sweep, R1 encodings throughout
      for (int ka = 0; ka < 17; ka++) begin
         for (int kb = 0; kb < 17; kb++) begin
            a = (ka < 16) ? WW'(ka * 16) : WW'(255);
            b = (kb < 16) ? WW'(kb * 16) : WW'(255);
            for (int i = 0; i < DEPTH; i++) prog[i] = enc(7, 0);
            prog[0] = enc(2, 30);
            prog[1] = enc(0, 31);
            prog[2] = enc(3, 29);
            prog[3] = enc(1, 31);
            prog[4] = enc(1, 31);
            prog[5] = enc(3, 28);
            prog[6] = enc(4 + ((ka + kb) % 4), 29);
            prog[7] = enc(2, 29);
            prog[8] = enc(3, 27);
            prog[30] = a; prog[31] = b;
            start();
            run(9);
            chk(mem[29] == WW'(a + b), "R5 stored sum", int'(mem[29]), int'(WW'(a + b)));
            chk(mem[28] == WW'(a - b), "R6 stored diff", int'(mem[28]), int'(WW'(a - b)));
            chk(mem[27] == WW'(a + b), "R10 no write", int'(mem[27]), int'(WW'(a + b)));
         end
      end
      // R11: program rewrites slot 3 with an add and executes it
      for (int i = 0; i < DEPTH; i++) prog[i] = enc(7, 0);
      prog[0]  = enc(2, 30);
      prog[1]  = enc(3, 3);
      prog[2]  = enc(5, 0);
      prog[4]  = enc(3, 26);
      prog[30] = enc(0, 31);
      prog[31] = 8'h25;
      start();
      run(5);
      chk(mem[26] == 8'h44, "R11 self-written add", int'(mem[26]), 68);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : watchdog
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule